// File: doc/BRIEF.md
# Minicomputer condition-code ALU

This block is the arithmetic and logic unit of a 16-bit minicomputer-style processor. Each accepted request carries an operation code, a byte/word select, a source operand, a destination operand and the present condition codes. One clock later the block returns the new destination value, the updated N, Z, V and C flags, and a write-back enable. The enable tells the surrounding datapath whether the destination should be overwritten.

The flag rules are specific to each operation, not those of a generic adder. Increment and decrement keep the carry. Every shift or rotate derives V from the final N and C. Compare subtracts the destination from the source and writes nothing. Byte swap takes its flags from the low half of its result. Sign extend is driven by the incoming N.

In byte mode the computation runs on the low 8 bits, with the sign at bit 7. The upper byte of the destination passes through unchanged. Decode, addressing, memory and traps are handled elsewhere.

Top module: `mini_alu`

## Requirements
- R1: After reset `out_valid`, `result`, `flags_out` and `wr_en` are all zero. Each `in_valid` cycle yields `out_valid` exactly one clock later. A cycle without `in_valid` yields `out_valid=0` and `wr_en=0` one clock later. Flags on `flags_in`/`flags_out` are packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R2: ADD (op 5) writes dst+src, with C the carry out and V the signed overflow. SUB (op 6) writes dst−src, with C the borrow. CMP (op 1) forms src−dst and sets all four flags as a subtraction would (C = borrow), but drives `wr_en=0` and returns dst unchanged.
- R3: INC (op 10) and DEC (op 11) write dst±1 and set N, Z and V. V is set when the value crosses between the most positive and most negative numbers. C keeps its incoming value.
- R4: COM (op 9) writes ~dst with V=0 and C=1. NEG (op 12) writes −dst, with V=1 only when the result is the most negative value and C=1 whenever the result is nonzero.
- R5: ROR (op 14) and ROL (op 15) rotate through C. ASR (op 16) shifts right and keeps the sign bit. ASL (op 17) shifts left and fills a zero. In each case C receives the bit shifted out and V = N xor C of the final result.
- R6: ADC (op 18) writes dst+C, with C set only if dst was all ones and C was 1. SBC (op 19) writes dst−C, with C set only if dst was zero and C was 1. For both, V is the signed overflow of that step.
- R7: SWAB (op 20) exchanges the two bytes of the word. N is bit 7 of the result, Z is set when the low result byte is zero, and V=C=0. The byte/word select has no effect on SWAB.
- R8: SXT (op 21) writes all ones when the incoming N is 1 and zero when it is 0. Z is the inverse of the incoming N, V=0, and N and C are kept. The byte/word select has no effect on SXT.
- R9: When `byte_mode=1`, operations 0–19 compute on bits 7:0, with the sign at bit 7 and overflow and carry at that width. Result bits 15:8 equal dst bits 15:8.
- R10: MOV (op 0), BIC (op 3, dst & ~src), BIS (op 4, dst | src) and XOR (op 7) write their result, clear V and keep C. BIT (op 2) sets N and Z from src & dst, clears V, keeps C and does not write. CLR (op 8) writes zero and sets the flags to 0100. TST (op 13) does not write, sets N and Z from dst and clears V and C. Unless a requirement says otherwise, N is the sign of the flag value and Z means that value is zero.
- R11: Op codes 22–31 are inert. They drive `wr_en=0`, return dst unchanged and pass `flags_in` through to `flags_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| flags_in | input | 4 | Current N,Z,V,C |
| out_valid | output | 1 | Result present |
| result | output | 16 | New destination value |
| flags_out | output | 4 | New N,Z,V,C |
| wr_en | output | 1 | Destination must be written |

## Verification
The only state is the single output stage, so a fault shows at the ports exactly one clock after the request that caused it. A lost `in_valid` appears as a missing `out_valid`. A carry that should have been kept but was recomputed shows as a flipped C on that same response. A wrong operand order in compare or subtract shows as an inverted C and N. A byte-mode lane that leaks its width shows as altered upper result bits or a sign taken from bit 15.

// File: rtl/minialu_pkg.sv
package minialu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 5'd0,
        OP_CMP  = 5'd1,
        OP_BIT  = 5'd2,
        OP_BIC  = 5'd3,
        OP_BIS  = 5'd4,
        OP_ADD  = 5'd5,
        OP_SUB  = 5'd6,
        OP_XOR  = 5'd7,
        OP_CLR  = 5'd8,
        OP_COM  = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_NEG  = 5'd12,
        OP_TST  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ASR  = 5'd16,
        OP_ASL  = 5'd17,
        OP_ADC  = 5'd18,
        OP_SBC  = 5'd19,
        OP_SWAB = 5'd20,
        OP_SXT  = 5'd21
    } alu_op_e;

    // condition codes, packed N,Z,V,C from MSB to LSB
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/mini_alu_adder.sv
module mini_alu_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          ci_i,
    output logic [DW-1:0] sum_o,
    output logic          co_o,
    output logic          ovf_o
);
    localparam int MSB = DW - 1;

    logic [DW:0] full;

    assign full  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci_i};
    assign sum_o = full[MSB:0];
    assign co_o  = full[DW];
    // signed overflow: like-signed inputs give an unlike-signed sum
    assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/mini_alu_shift.sv
module mini_alu_shift
    import minialu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] val_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    localparam int MSB = DW - 1;

    always_comb begin
        res_o  = val_i;
        cout_o = cin_i;
        case (op_i)
            OP_ROR: begin
                res_o  = {cin_i, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_ROL: begin
                res_o  = {val_i[MSB-1:0], cin_i};
                cout_o = val_i[MSB];
            end
            OP_ASR: begin
                res_o  = {val_i[MSB], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_ASL: begin
                res_o  = {val_i[MSB-1:0], 1'b0};
                cout_o = val_i[MSB];
            end
            default: begin
                res_o  = val_i;
                cout_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/mini_alu_core.sv
module mini_alu_core
    import minialu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_i,
    input  cc_t           cc_i,
    output logic [DW-1:0] res_o,
    output cc_t           cc_o,
    output logic          wr_o
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] add_a, add_b, add_sum;
    logic          add_ci, add_co, add_ovf;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] nz_val;
    logic          nz_upd;

    // operand steering for the shared adder
    always_comb begin
        add_a  = dst_i;
        add_b  = '0;
        add_ci = 1'b0;
        case (op_i)
            OP_ADD: add_b = src_i;
            OP_SUB: begin add_b = ~src_i; add_ci = 1'b1; end
            OP_CMP: begin add_a = src_i; add_b = ~dst_i; add_ci = 1'b1; end
            OP_INC: add_ci = 1'b1;
            OP_DEC: add_b = '1;
            OP_NEG: begin add_a = '0; add_b = ~dst_i; add_ci = 1'b1; end
            OP_ADC: add_ci = cc_i.c;
            OP_SBC: begin add_b = '1; add_ci = ~cc_i.c; end
            default: ;
        endcase
    end

    mini_alu_adder #(.DW(DW)) u_adder (
        .a_i   (add_a),
        .b_i   (add_b),
        .ci_i  (add_ci),
        .sum_o (add_sum),
        .co_o  (add_co),
        .ovf_o (add_ovf)
    );

    mini_alu_shift #(.DW(DW)) u_shift (
        .op_i   (op_i),
        .val_i  (dst_i),
        .cin_i  (cc_i.c),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    always_comb begin
        res_o  = dst_i;
        cc_o   = cc_i;
        wr_o   = 1'b1;
        nz_upd = 1'b1;
        nz_val = dst_i;
        case (op_i)
            OP_MOV: begin
                res_o = src_i; nz_val = src_i; cc_o.v = 1'b0;
            end
            OP_CMP: begin
                wr_o = 1'b0; nz_val = add_sum;
                cc_o.v = add_ovf; cc_o.c = ~add_co;
            end
            OP_BIT: begin
                wr_o = 1'b0; nz_val = src_i & dst_i; cc_o.v = 1'b0;
            end
            OP_BIC: begin
                res_o = dst_i & ~src_i; nz_val = res_o; cc_o.v = 1'b0;
            end
            OP_BIS: begin
                res_o = dst_i | src_i; nz_val = res_o; cc_o.v = 1'b0;
            end
            OP_XOR: begin
                res_o = dst_i ^ src_i; nz_val = res_o; cc_o.v = 1'b0;
            end
            OP_ADD, OP_ADC: begin
                res_o = add_sum; nz_val = add_sum;
                cc_o.v = add_ovf; cc_o.c = add_co;
            end
            OP_SUB, OP_SBC: begin
                res_o = add_sum; nz_val = add_sum;
                cc_o.v = add_ovf; cc_o.c = ~add_co;
            end
            OP_CLR: begin
                res_o = '0; nz_val = '0; cc_o.v = 1'b0; cc_o.c = 1'b0;
            end
            OP_COM: begin
                res_o = ~dst_i; nz_val = res_o; cc_o.v = 1'b0; cc_o.c = 1'b1;
            end
            OP_INC, OP_DEC: begin
                // carry deliberately untouched
                res_o = add_sum; nz_val = add_sum; cc_o.v = add_ovf;
            end
            OP_NEG: begin
                res_o = add_sum; nz_val = add_sum;
                cc_o.v = add_ovf; cc_o.c = |add_sum;
            end
            OP_TST: begin
                wr_o = 1'b0; nz_val = dst_i; cc_o.v = 1'b0; cc_o.c = 1'b0;
            end
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin
                res_o  = sh_res; nz_val = sh_res;
                cc_o.c = sh_c;
                cc_o.v = sh_res[MSB] ^ sh_c;
            end
            default: begin
                wr_o = 1'b0; nz_upd = 1'b0;
            end
        endcase
        if (nz_upd) begin
            cc_o.n = nz_val[MSB];
            cc_o.z = (nz_val == '0);
        end
    end

endmodule

// File: rtl/mini_alu.sv
module mini_alu
    import minialu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              wr_en
);
    localparam int BYTE_W   = WORD_W / 2;
    localparam int LAST_CORE = 19;
    localparam int LAST_OP   = 21;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        cc_t               cc;
        logic              wr;
    } stage_t;

    stage_t  st_d, st_q;
    alu_op_e opc;
    cc_t     cc_in;

    logic [WORD_W-1:0] w_res;
    cc_t               w_cc;
    logic              w_wr;
    logic [BYTE_W-1:0] b_res;
    cc_t               b_cc;
    logic              b_wr;
    logic [WORD_W-1:0] swab_val;

    assign opc      = alu_op_e'(op);
    assign cc_in    = cc_t'(flags_in);
    assign swab_val = {dst[BYTE_W-1:0], dst[WORD_W-1:BYTE_W]};

    // full-width lane
    mini_alu_core #(.DW(WORD_W)) u_word (
        .op_i  (opc),
        .src_i (src),
        .dst_i (dst),
        .cc_i  (cc_in),
        .res_o (w_res),
        .cc_o  (w_cc),
        .wr_o  (w_wr)
    );

    // low-byte lane
    mini_alu_core #(.DW(BYTE_W)) u_byte (
        .op_i  (opc),
        .src_i (src[BYTE_W-1:0]),
        .dst_i (dst[BYTE_W-1:0]),
        .cc_i  (cc_in),
        .res_o (b_res),
        .cc_o  (b_cc),
        .wr_o  (b_wr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wr  = 1'b0;
        if (in_valid) begin
            st_d.cc = cc_in;
            case (opc)
                OP_SWAB: begin
                    st_d.res  = swab_val;
                    st_d.cc.n = swab_val[BYTE_W-1];
                    st_d.cc.z = (swab_val[BYTE_W-1:0] == '0);
                    st_d.cc.v = 1'b0;
                    st_d.cc.c = 1'b0;
                    st_d.wr   = 1'b1;
                end
                OP_SXT: begin
                    st_d.res  = cc_in.n ? '1 : '0;
                    st_d.cc.z = ~cc_in.n;
                    st_d.cc.v = 1'b0;
                    st_d.wr   = 1'b1;
                end
                default: begin
                    if (byte_mode) begin
                        st_d.res = {dst[WORD_W-1:BYTE_W], b_res};
                        st_d.cc  = b_cc;
                        st_d.wr  = b_wr;
                    end else begin
                        st_d.res = w_res;
                        st_d.cc  = w_cc;
                        st_d.wr  = w_wr;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flags_out = st_q.cc;
    assign wr_en     = st_q.wr;

    // ---------------- assertions ----------------
    p_resp_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en));
    p_cmp_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_CMP)) |=> (!wr_en && result == $past(dst)));
    p_incdec_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_INC || op == OP_DEC)) |=> (flags_out[0] == $past(flags_in[0])));
    p_com_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_COM)) |=> (flags_out[0] && !flags_out[1]));
    p_shift_v_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= OP_ROR && op <= OP_ASL) |=> (flags_out[1] == (flags_out[3] ^ flags_out[0])));
    p_byte_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && byte_mode && op <= 5'(LAST_CORE)) |=> (result[WORD_W-1:BYTE_W] == $past(dst[WORD_W-1:BYTE_W])));
    p_inert_op_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 5'(LAST_OP)) |=> (!wr_en && flags_out == $past(flags_in) && result == $past(dst)));

endmodule

// File: tb/mini_alu_bench.sv
module mini_alu_bench;

    localparam int PERIOD = 10;
    localparam int WDOG   = 5000;

    localparam logic [4:0] MOV = 5'd0,  CMP = 5'd1,  BIT = 5'd2,  BIC = 5'd3;
    localparam logic [4:0] BIS = 5'd4,  ADD = 5'd5,  SUB = 5'd6,  XOR = 5'd7;
    localparam logic [4:0] CLR = 5'd8,  COM = 5'd9,  INC = 5'd10, DEC = 5'd11;
    localparam logic [4:0] NEG = 5'd12, TST = 5'd13, ROR = 5'd14, ROL = 5'd15;
    localparam logic [4:0] ASR = 5'd16, ASL = 5'd17, ADC = 5'd18, SBC = 5'd19;
    localparam logic [4:0] SWB = 5'd20, SXT = 5'd21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] src = '0;
    logic [15:0] dst = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [3:0]  flags_out;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        vld;
        logic [15:0] res;
        logic [3:0]  cc;
        logic        wr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    mini_alu u_mini_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .byte_mode (byte_mode),
        .src       (src),
        .dst       (dst),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    task automatic drive(input logic [4:0] o, input logic bm, input logic [15:0] s,
                         input logic [15:0] d, input logic [3:0] fi,
                         input logic [15:0] eres, input logic [3:0] ecc,
                         input logic ewr, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; byte_mode = bm; src = s; dst = d; flags_in = fi;
        e.vld = 1'b1; e.res = eres; e.cc = ecc; e.wr = ewr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; op = 5'd3; src = 16'hFFFF; dst = 16'h1234;
        e.vld = 1'b0; e.res = '0; e.cc = '0; e.wr = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare one expected item per clock, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (!e.vld) begin
                    if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
                        errors++;
                        $display("FAIL %s idle: out_valid=%b wr_en=%b expected 0 0",
                                 e.tag, out_valid, wr_en);
                    end
                end else if (out_valid !== 1'b1 || result !== e.res ||
                             flags_out !== e.cc || wr_en !== e.wr) begin
                    errors++;
                    $display("FAIL %s: vld=%b res=%o flags=%b wr=%b expected vld=1 res=%o flags=%b wr=%b",
                             e.tag, out_valid, result, flags_out, wr_en, e.res, e.cc, e.wr);
                end
            end
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 16'h0 || flags_out !== 4'h0 || wr_en !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: vld=%b res=%o flags=%b wr=%b expected all zero",
                     out_valid, result, flags_out, wr_en);
        end
        rst = 1'b0;

        // word operations (flags N Z V C)
        drive(MOV, 0, 16'o004711, 16'o123456, 4'b0001, 16'o004711, 4'b0001, 1, "R10 mov keeps C");
        drive(CMP, 0, 16'o004711, 16'o123456, 4'b0000, 16'o123456, 4'b0001, 0, "R2 cmp borrow");
        drive(CMP, 0, 16'o123456, 16'o004711, 4'b0000, 16'o004711, 4'b1000, 0, "R2 cmp negative");
        drive(CMP, 0, 16'o004711, 16'o004711, 4'b0000, 16'o004711, 4'b0100, 0, "R2 cmp equal");
        drive(CLR, 0, 16'o0,      16'o123456, 4'b1111, 16'o000000, 4'b0100, 1, "R10 clr");
        drive(BIT, 0, 16'o004711, 16'o000011, 4'b0000, 16'o000011, 4'b0000, 0, "R10 bit nonzero");
        drive(BIT, 0, 16'o004711, 16'o000066, 4'b0001, 16'o000066, 4'b0101, 0, "R10 bit zero");
        drive(BIC, 0, 16'o004711, 16'o123456, 4'b0000, 16'o123046, 4'b1000, 1, "R10 bic");
        drive(BIS, 0, 16'o004711, 16'o123456, 4'b0000, 16'o127757, 4'b1000, 1, "R10 bis");
        drive(ADD, 0, 16'o004711, 16'o123456, 4'b0000, 16'o130367, 4'b1000, 1, "R2 add");
        drive(SUB, 0, 16'o004711, 16'o123456, 4'b0000, 16'o116545, 4'b1000, 1, "R2 sub");
        idle("R1 bubble");
        drive(COM, 0, 16'o0,      16'o123456, 4'b0000, 16'o054321, 4'b0001, 1, "R4 com");
        drive(INC, 0, 16'o0,      16'o123456, 4'b0001, 16'o123457, 4'b1001, 1, "R3 inc keeps C");
        drive(DEC, 0, 16'o0,      16'o123456, 4'b0001, 16'o123455, 4'b1001, 1, "R3 dec keeps C");
        drive(NEG, 0, 16'o0,      16'o123456, 4'b0000, 16'o054322, 4'b0001, 1, "R4 neg");
        drive(TST, 0, 16'o0,      16'o123456, 4'b0011, 16'o123456, 4'b1000, 0, "R10 tst");
        drive(ROR, 0, 16'o0,      16'o100201, 4'b0000, 16'o040100, 4'b0011, 1, "R5 ror C0");
        drive(ROR, 0, 16'o0,      16'o002201, 4'b0001, 16'o101100, 4'b1001, 1, "R5 ror C1");
        drive(ROL, 0, 16'o0,      16'o100200, 4'b0001, 16'o000401, 4'b0011, 1, "R5 rol");
        drive(ASR, 0, 16'o0,      16'o000200, 4'b0000, 16'o000100, 4'b0000, 1, "R5 asr pos");
        drive(ASR, 0, 16'o0,      16'o100200, 4'b0000, 16'o140100, 4'b1010, 1, "R5 asr neg");
        drive(ASL, 0, 16'o0,      16'o000200, 4'b0000, 16'o000400, 4'b0000, 1, "R5 asl pos");
        drive(ASL, 0, 16'o0,      16'o100200, 4'b0000, 16'o000400, 4'b0011, 1, "R5 asl neg");
        drive(ADD, 0, 16'o004711, 16'o177000, 4'b0000, 16'o003711, 4'b0001, 1, "R2 add carry");
        drive(ADC, 0, 16'o0,      16'o000200, 4'b0001, 16'o000201, 4'b0000, 1, "R6 adc");
        drive(SUB, 0, 16'o004711, 16'o004701, 4'b0000, 16'o177770, 4'b1001, 1, "R2 sub borrow");
        drive(SBC, 0, 16'o0,      16'o000200, 4'b0001, 16'o000177, 4'b0000, 1, "R6 sbc");
        drive(SWB, 0, 16'o0,      16'o111000, 4'b0000, 16'o000222, 4'b1000, 1, "R7 swab");
        drive(SXT, 0, 16'o0,      16'o111111, 4'b1000, 16'o177777, 4'b1000, 1, "R8 sxt N1");
        drive(XOR, 0, 16'o004711, 16'o070707, 4'b0010, 16'o074016, 4'b0000, 1, "R10 xor");
        drive(SXT, 0, 16'o0,      16'o111111, 4'b0001, 16'o000000, 4'b0101, 1, "R8 sxt N0");

        // boundary cases
        drive(INC, 0, 16'o0, 16'o077777, 4'b0000, 16'o100000, 4'b1010, 1, "R3 inc overflow");
        drive(DEC, 0, 16'o0, 16'o100000, 4'b0001, 16'o077777, 4'b0011, 1, "R3 dec overflow");
        drive(NEG, 0, 16'o0, 16'o100000, 4'b0000, 16'o100000, 4'b1011, 1, "R4 neg most negative");
        drive(NEG, 0, 16'o0, 16'o000000, 4'b0001, 16'o000000, 4'b0100, 1, "R4 neg zero");
        drive(ADC, 0, 16'o0, 16'o177777, 4'b0001, 16'o000000, 4'b0101, 1, "R6 adc wrap");
        drive(SBC, 0, 16'o0, 16'o000000, 4'b0001, 16'o177777, 4'b1001, 1, "R6 sbc wrap");
        drive(SBC, 0, 16'o0, 16'o100000, 4'b0001, 16'o077777, 4'b0010, 1, "R6 sbc overflow");
        drive(ADC, 0, 16'o0, 16'o000200, 4'b0000, 16'o000200, 4'b0000, 1, "R6 adc no carry");

        // byte mode, upper dst byte 0x5A must survive
        drive(MOV, 1, 16'o000123, {8'h5A, 8'o333}, 4'b0000, {8'h5A, 8'o123}, 4'b0000, 1, "R9 movb");
        drive(CMP, 1, 16'o000123, {8'h5A, 8'o333}, 4'b0000, {8'h5A, 8'o333}, 4'b0001, 0, "R9 cmpb");
        drive(BIC, 1, 16'o000123, {8'h5A, 8'o333}, 4'b0000, {8'h5A, 8'o210}, 4'b1000, 1, "R9 bicb");
        drive(ROR, 1, 16'o0,      {8'h5A, 8'o201}, 4'b0000, {8'h5A, 8'o100}, 4'b0011, 1, "R9 rorb");
        drive(INC, 1, 16'o0,      {8'h5A, 8'o321}, 4'b0001, {8'h5A, 8'o322}, 4'b1001, 1, "R9 incb");
        drive(INC, 1, 16'o0,      {8'h5A, 8'o177}, 4'b0000, {8'h5A, 8'o200}, 4'b1010, 1, "R9 incb overflow");
        drive(NEG, 1, 16'o0,      {8'h5A, 8'o321}, 4'b0000, {8'h5A, 8'o057}, 4'b0001, 1, "R9 negb");
        drive(ASR, 1, 16'o0,      {8'h5A, 8'o220}, 4'b0000, {8'h5A, 8'o310}, 4'b1010, 1, "R9 asrb");
        drive(ASL, 1, 16'o0,      {8'h5A, 8'o220}, 4'b0000, {8'h5A, 8'o040}, 4'b0011, 1, "R9 aslb");
        drive(ADD, 1, 16'o000001, {8'h5A, 8'o377}, 4'b0000, {8'h5A, 8'o000}, 4'b0101, 1, "R9 addb carry");
        drive(SWB, 1, 16'o0,      16'o111000,      4'b0000, 16'o000222,      4'b1000, 1, "R7 swab ignores byte");
        drive(SXT, 1, 16'o0,      16'o000123,      4'b1000, 16'o177777,      4'b1000, 1, "R8 sxt ignores byte");

        // inert codes
        drive(5'd22, 0, 16'o1, 16'o001234, 4'b1010, 16'o001234, 4'b1010, 0, "R11 code 22");
        drive(5'd31, 1, 16'o1, 16'o177001, 4'b0101, 16'o177001, 4'b0101, 0, "R11 code 31");
        idle("R1 trailing idle");
        idle("R1 trailing idle");

        @(negedge clk);
        in_valid = 1'b0;
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule